// File: doc/BRIEF.md
# DMA Trigger Source Router

This block decides, for each DMA channel, which event starts a transfer. Every channel has an enable bit, an end-of-transfer interrupt enable bit and a 3-bit source code. Codes 0 to 5 route one of six internal peripheral request strobes (four timer compare/capture requests and a serial port's transmit-empty and receive-full events) to the channel. On channels built as the "external" kind, codes 6 and 7 instead follow a per-channel active-low request pin, as an edge or as a level. On the other channels those two codes select full-address transfer mode, which starts no trigger from this block.

A peripheral event that an enabled channel claims is withheld from the CPU interrupt path. When several enabled channels claim the same internal source, one event is latched in each of them, and the channels are offered the trigger one at a time, lowest index first. Each channel answers with a one-cycle acknowledge. When software clears a channel's enable bit, a sticky end-of-transfer flag can be raised for the CPU.

Top module: `dma_trig_router`

## Requirements
- R1: After reset no trigger, full-address or end flag output is high, and each CPU interrupt output follows its peripheral input.
- R2: An enabled channel with code s (0 to 5) latches a strobe on peripheral input s. Its trigger output is high in the cycle after the strobe's clock edge, and it stays high until the channel is acknowledged.
- R3: A channel whose enable bit is 0 latches nothing. Any latched request it holds is dropped on the next clock edge.
- R4: CPU interrupt output s is forced low while any enabled channel has code s. With no enabled claimant it equals peripheral input s.
- R5: Enabled channels that share an internal code each latch the event. Only the lowest-index pending one drives its trigger. The others hold their request until every lower-index request is acknowledged.
- R6: An acknowledge clears the channel's latched request, and the trigger is low in the next cycle. A new internal strobe or edge in the same cycle as the acknowledge wins over it.
- R7: On an external-kind channel, code 6 latches one request per falling edge of its pin. The pin passes two synchronizing flops, so a low first sampled at edge k gives a trigger after edge k+2. A pin that stays low does not request again.
- R8: On an external-kind channel, code 7 requests while the synchronized pin is low. An acknowledge forces one low trigger cycle, after which the request is raised again if the pin is still low.
- R9: On the other channel kind, codes 6 and 7 never trigger and ignore the pin. The full-address output is high while the channel is enabled with either of those codes.
- R10: The end flag is set on the clock edge after the enable bit falls from 1 to 0, but only if the end interrupt enable bit is 1 in that cycle.
- R11: The end flag stays set until an end-clear strobe for that channel. A clear in the same cycle as a new set leaves the flag set.
- R12: Codes 6 and 7 mask no CPU interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en_i | input | NCH | Channel enable bits |
| ch_endie_i | input | NCH | End-of-transfer interrupt enable bits |
| ch_sel_i | input | NCH*3 | Source code per channel, channel i at bits [3i+2:3i] |
| periph_req_i | input | 6 | Peripheral request strobes, index equals source code |
| dreq_n_i | input | NCH | Active-low external request pins, one per channel |
| ch_ack_i | input | NCH | One-cycle acknowledge from each channel |
| end_clr_i | input | NCH | Write-one-to-clear strobes for the end flags |
| ch_trig_o | output | NCH | Transfer trigger per channel |
| ch_full_addr_o | output | NCH | Full-address mode selected and enabled |
| cpu_irq_o | output | 6 | Peripheral interrupts passed to the CPU after masking |
| end_irq_o | output | NCH | Sticky end-of-transfer flags |

## Verification
Masking, full-address mode and the choice among sharing channels are combinational, so they are due in the same cycle as the control inputs. A latched request, an acknowledge and an end-flag change appear one edge after their cause. A request from the pin needs three edges, two for synchronizing and one for latching. The bench model advances its state at each rising edge from the inputs held over that cycle. One nanosecond later it compares all four outputs against values computed from its own state and the current inputs, so every result is checked in the first cycle it is due and in every cycle after.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 6;
    localparam logic [SEL_W-1:0] SEL_PIN_EDGE  = 3'd6;
    localparam logic [SEL_W-1:0] SEL_PIN_LEVEL = 3'd7;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } pin_sync_t;

    typedef struct packed {
        logic pend;
        logic done;
        logic en_seen;
    } chan_st_t;
endpackage

// File: rtl/dmar_pin_sync.sv
module dmar_pin_sync
    import dmar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic fall_o,
    output logic low_o
);
    pin_sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_n_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign fall_o = st_q.s3 & ~st_q.s2;
    assign low_o  = ~st_q.s2;

    // R7: a held-low pin produces a single edge event
    p_edge_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
    import dmar_pkg::*;
#(
    parameter bit IS_EXT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             endie_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic             fall_i,
    input  logic             low_i,
    input  logic             ack_i,
    input  logic             clr_i,
    output logic             pend_o,
    output logic             done_o
);
    localparam int SEL_N = 1 << SEL_W;

    chan_st_t st_d, st_q;
    logic [SEL_N-1:0] req_ext;
    logic hit, edge_set, lvl_set, end_set;

    always_comb begin
        req_ext                = '0;
        req_ext[NUM_SRC-1:0]   = req_i;
        hit      = req_ext[sel_i];
        edge_set = IS_EXT && (sel_i == SEL_PIN_EDGE) && fall_i;
        lvl_set  = IS_EXT && (sel_i == SEL_PIN_LEVEL) && low_i && !ack_i;
        end_set  = st_q.en_seen && !en_i && endie_i;

        st_d         = st_q;
        st_d.pend    = en_i && ((st_q.pend && !ack_i) || hit || edge_set || lvl_set);
        st_d.done    = (st_q.done && !clr_i) || end_set;
        st_d.en_seen = en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign done_o = st_q.done;

    p_off_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pend_o);

    p_level_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_EXT && ack_i && sel_i == SEL_PIN_LEVEL) |=> !pend_o);

    p_end_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en_seen && !en_i && endie_i) |=> done_o);

    p_end_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(st_q.en_seen && !en_i && endie_i)) |=> !done_o);
endmodule

// File: rtl/dma_trig_router.sv
module dma_trig_router
    import dmar_pkg::*;
#(
    parameter int             NCH    = 4,
    parameter logic [NCH-1:0] CH_EXT = 4'b1010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ch_en_i,
    input  logic [NCH-1:0]       ch_endie_i,
    input  logic [NCH*SEL_W-1:0] ch_sel_i,
    input  logic [NUM_SRC-1:0]   periph_req_i,
    input  logic [NCH-1:0]       dreq_n_i,
    input  logic [NCH-1:0]       ch_ack_i,
    input  logic [NCH-1:0]       end_clr_i,
    output logic [NCH-1:0]       ch_trig_o,
    output logic [NCH-1:0]       ch_full_addr_o,
    output logic [NUM_SRC-1:0]   cpu_irq_o,
    output logic [NCH-1:0]       end_irq_o
);
    localparam logic [SEL_W-1:0] SRC_LIM = SEL_W'(NUM_SRC);

    logic [SEL_W-1:0] sel_a [NCH];
    logic [NCH-1:0]   pend;
    logic [NCH-1:0]   pin_fall, pin_low;
    logic [NCH-1:0]   blocked;
    logic [NCH-1:0]   share_m [NUM_SRC];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign sel_a[i] = ch_sel_i[i*SEL_W +: SEL_W];

        dmar_pin_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n_i (dreq_n_i[i]),
            .fall_o  (pin_fall[i]),
            .low_o   (pin_low[i])
        );

        dmar_chan #(.IS_EXT(CH_EXT[i])) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (ch_en_i[i]),
            .endie_i (ch_endie_i[i]),
            .sel_i   (sel_a[i]),
            .req_i   (periph_req_i),
            .fall_i  (pin_fall[i]),
            .low_i   (pin_low[i]),
            .ack_i   (ch_ack_i[i]),
            .clr_i   (end_clr_i[i]),
            .pend_o  (pend[i]),
            .done_o  (end_irq_o[i])
        );

        assign ch_full_addr_o[i] = !CH_EXT[i] && ch_en_i[i] &&
                                   (sel_a[i] == SEL_PIN_EDGE || sel_a[i] == SEL_PIN_LEVEL);
    end

    // fixed priority among channels sharing one internal source
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (pend[j] && ch_en_i[j] && sel_a[j] == sel_a[i]) blocked[i] = 1'b1;
            end
            ch_trig_o[i] = pend[i] && !(blocked[i] && sel_a[i] < SRC_LIM);
        end
    end

    // CPU interrupt masking by claiming channels
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int i = 0; i < NCH; i++) begin
                share_m[s][i] = ch_en_i[i] && (sel_a[i] == SEL_W'(s));
            end
            cpu_irq_o[s] = periph_req_i[s] && !(|share_m[s]);
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        p_claim_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (|share_m[s]) |-> !cpu_irq_o[s]);

        p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(ch_trig_o & share_m[s]));
    end
endmodule

// File: tb/dma_trig_router_tb.sv
`timescale 1ns/1ps
module dma_trig_router_tb;
    localparam int NCH = 4;
    localparam logic [NCH-1:0] EXT = 4'b1010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]   ch_en = '0, ch_endie = '0, dreq_n = '1, ack = '0, clr = '0;
    logic [NCH*3-1:0] ch_sel = '0;
    logic [5:0]       periph = '0;
    logic [NCH-1:0]   trig, full_addr, end_irq;
    logic [5:0]       cpu_irq;

    int check_cnt = 0;
    int fail_cnt  = 0;
    string cur_req = "R1";

    bit m_pend[NCH], m_done[NCH], m_seen[NCH], m_s1[NCH], m_s2[NCH], m_s3[NCH];

    always #2.5 clk = ~clk;

    dma_trig_router #(.NCH(NCH), .CH_EXT(EXT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_en_i(ch_en), .ch_endie_i(ch_endie),
        .ch_sel_i(ch_sel), .periph_req_i(periph), .dreq_n_i(dreq_n),
        .ch_ack_i(ack), .end_clr_i(clr), .ch_trig_o(trig),
        .ch_full_addr_o(full_addr), .cpu_irq_o(cpu_irq), .end_irq_o(end_irq)
    );

    function automatic int sel_of(int i);
        return int'(ch_sel[i*3 +: 3]);
    endfunction

    task automatic model_step();
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                m_pend[i] = 0; m_done[i] = 0; m_seen[i] = 0;
                m_s1[i] = 1; m_s2[i] = 1; m_s3[i] = 1;
            end else begin
                int  sl   = sel_of(i);
                bit  en   = ch_en[i];
                bit  hit  = (sl < 6) && periph[sl];
                bit  fall = EXT[i] && sl == 6 && m_s3[i] && !m_s2[i];
                bit  low  = EXT[i] && sl == 7 && !m_s2[i] && !ack[i];
                bit  np   = en && ((m_pend[i] && !ack[i]) || hit || fall || low);
                bit  nd   = (m_done[i] && !clr[i]) || (m_seen[i] && !en && ch_endie[i]);
                m_pend[i] = np;
                m_done[i] = nd;
                m_seen[i] = en;
                m_s3[i]   = m_s2[i];
                m_s2[i]   = m_s1[i];
                m_s1[i]   = dreq_n[i];
            end
        end
    endtask

    task automatic check_vec(string what, logic [7:0] act, logic [7:0] exp);
        check_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] e_trig = '0, e_full = '0, e_cpu = '0, e_end = '0;
        for (int i = 0; i < NCH; i++) begin
            bit blk = 0;
            for (int j = 0; j < i; j++)
                if (m_pend[j] && ch_en[j] && sel_of(j) == sel_of(i)) blk = 1;
            e_trig[i] = m_pend[i] && !(blk && sel_of(i) < 6);
            e_full[i] = !EXT[i] && ch_en[i] && sel_of(i) >= 6;
            e_end[i]  = m_done[i];
        end
        for (int s = 0; s < 6; s++) begin
            bit claimed = 0;
            for (int i = 0; i < NCH; i++) if (ch_en[i] && sel_of(i) == s) claimed = 1;
            e_cpu[s] = periph[s] && !claimed;
        end
        check_vec("trigger",      {4'b0, trig},      e_trig);
        check_vec("full-address", {4'b0, full_addr}, e_full);
        check_vec("cpu irq",      {2'b0, cpu_irq},   e_cpu);
        check_vec("end flag",     {4'b0, end_irq},   e_end);
    endtask

    task automatic cyc(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_step();
            #1 compare();
        end
    endtask

    task automatic set_ch(int i, bit en, bit endie, int sel);
        ch_en[i] = en;
        ch_endie[i] = endie;
        ch_sel[i*3 +: 3] = 3'(sel);
    endtask

    task automatic pulse_src(int s);
        periph[s] = 1'b1; cyc(); periph[s] = 1'b0;
    endtask

    task automatic do_ack(int i);
        ack[i] = 1'b1; cyc(); ack[i] = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
        $finish;
    endtask

    initial begin
        #500000;
        check_cnt++; fail_cnt++;
        $display("FAIL watchdog %s: actual hung expected done", cur_req);
        summary();
    end

    initial begin
        cur_req = "R1"; cyc(3);
        rst_n = 1'b1; cyc(2);

        cur_req = "R4";
        for (int s = 0; s < 6; s++) pulse_src(s);
        set_ch(0, 1, 0, 2); cyc();
        pulse_src(2); pulse_src(5);

        cur_req = "R2"; cyc(2); do_ack(0); cyc(2);
        for (int s = 0; s < 6; s++) begin
            set_ch(2, 1, 0, s); pulse_src(s); cyc(); do_ack(2); cyc();
        end

        cur_req = "R5";
        set_ch(0, 1, 0, 4); set_ch(2, 1, 0, 4); cyc();
        pulse_src(4); cyc(2);
        cur_req = "R6"; do_ack(0); cyc(2);
        pulse_src(4); do_ack(2); cyc();
        ack[2] = 1'b1; periph[4] = 1'b1; cyc(); ack[2] = 1'b0; periph[4] = 1'b0;
        do_ack(0); cyc(); do_ack(2); cyc(2);

        cur_req = "R3";
        set_ch(0, 0, 0, 4); set_ch(2, 0, 0, 4); pulse_src(4); cyc(2);
        set_ch(0, 1, 0, 3); pulse_src(3); set_ch(0, 0, 0, 3); cyc(3);

        cur_req = "R7";
        set_ch(1, 1, 0, 6); cyc();
        dreq_n[1] = 1'b0; cyc(6); do_ack(1); cyc(3);
        dreq_n[1] = 1'b1; cyc(3); dreq_n[1] = 1'b0; cyc(4); do_ack(1);
        dreq_n[1] = 1'b1; cyc(3);

        cur_req = "R8";
        set_ch(3, 1, 0, 7); cyc();
        dreq_n[3] = 1'b0; cyc(4); do_ack(3); cyc(); do_ack(3); cyc(2);
        dreq_n[3] = 1'b1; cyc(4); do_ack(3); cyc(3);

        cur_req = "R9";
        set_ch(0, 1, 0, 6); dreq_n[0] = 1'b0; cyc(5);
        set_ch(0, 1, 0, 7); cyc(4); dreq_n[0] = 1'b1; cyc(2);

        cur_req = "R12";
        set_ch(2, 1, 0, 7); cyc();
        for (int s = 0; s < 6; s++) pulse_src(s);

        cur_req = "R10";
        set_ch(1, 1, 1, 6); cyc(); set_ch(1, 0, 1, 6); cyc(3);
        set_ch(3, 1, 0, 7); cyc(); set_ch(3, 0, 0, 7); cyc(3);

        cur_req = "R11";
        clr[1] = 1'b1; cyc(); clr[1] = 1'b0; cyc(2);
        set_ch(2, 1, 1, 7); cyc();
        set_ch(2, 0, 1, 7); clr[2] = 1'b1; cyc(); clr[2] = 1'b0; cyc(2);
        clr[2] = 1'b1; cyc(); clr[2] = 1'b0; cyc(2);

        summary();
    end
endmodule